// File: doc/BRIEF.md
# Line-Region Clamp and Blank Pulse Sequencer

This block produces one horizontal timing pulse for an image sensor front end, for example an optical-black clamp, a dummy-pixel clamp or a preblank window. It keeps a 12-bit pixel counter and a 12-bit line counter. The horizontal and vertical sync strobes reset these counters. From the two counts it decides the level of the pulse on every pixel clock.

The pulse shape is not one fixed window. The block holds four pulse patterns. Each pattern is a start level plus two toggle pixels. Four change lines divide the field into vertical regions. Change line 0 is wired to line 0, and the other three are programmable. Each change line has a 2-bit pointer that chooses which pattern is used from that line onward. In this way, different bands of lines (black rows, active rows, trailing rows) can each carry their own clamp or blank shape. An external mode ignores all of this and passes an external pulse through to the output, with its polarity normalised.

The configuration arrives as static input vectors from a register bank outside the block. The timing of register updates is the caller's concern.

Top module: `lrs_pulse_seq`

## Requirements
- R1: A cycle with `hsync_i` high clears the pixel count to 0 at the next clock edge. Any other cycle adds 1 to the count, which wraps from 4095 to 0.
- R2: A cycle with `vsync_i` high clears the line count to 0, and this takes priority over `hsync_i`. A cycle with only `hsync_i` high adds 1 to the line count. A cycle with neither holds the line count.
- R3: In internal mode, `pulse_o` starts each line at the selected pattern's start level (`seq_pol_i[s]`). It inverts once the pixel count reaches `tog_a` and inverts again once it reaches `tog_b`, so the level is pol XOR (pix>=tog_a) XOR (pix>=tog_b). When the two toggles are equal, the output keeps the start level for the whole line.
- R4: A toggle pixel of 0xFFF is reached only at pixel 4095. In lines shorter than 4096 pixels it has no effect on `pulse_o`.
- R5: The pattern index comes from the pointer of the active change position. Pattern s has its fields at `seq_pol_i[s]`, `seq_tog_a_i[12s+:12]` and `seq_tog_b_i[12s+:12]`. Change position k (1..3) has its line at `chg_line_i[12(k-1)+:12]`. Pointer k sits at `chg_ptr_i[2k+:2]`. Position 0 is always at line 0.
- R6: The active change position is the highest-indexed position whose line is less than or equal to the current line count. This rule holds even when the programmed lines are out of ascending order.
- R7: With `ext_mode_i`=1, `pulse_o` equals `ext_pulse_i` when `ext_pol_i`=1 and equals its inverse when `ext_pol_i`=0. The counters and patterns have no effect on `pulse_o` in this mode.
- R8: While `rst_ni` is low, both counters read 0. In internal mode, `pulse_o` then shows the pattern chosen by pointer 0, evaluated at pixel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Line-start strobe, one cycle high |
| vsync_i | input | 1 | Field-start strobe, one cycle high |
| seq_pol_i | input | 4 | Start level of each pattern |
| seq_tog_a_i | input | 48 | First toggle pixel of each pattern, 12 bits each |
| seq_tog_b_i | input | 48 | Second toggle pixel of each pattern, 12 bits each |
| chg_line_i | input | 36 | Lines of change positions 1..3, 12 bits each |
| chg_ptr_i | input | 8 | Pattern pointer of change positions 0..3, 2 bits each |
| ext_mode_i | input | 1 | 0 = internal pattern, 1 = external pass-through |
| ext_pol_i | input | 1 | Active level of the external pulse (1 = high) |
| ext_pulse_i | input | 1 | External pulse |
| pulse_o | output | 1 | Generated pulse |

## Verification
The assertions check the counter rules on every cycle: clear on sync, increment with wrap, the line count held without a strobe, and vsync taking priority. They also check that the output follows the pattern of pointer 0 above every programmed change line, and that in external mode the output does not move unless the external input or its polarity moves. Only the bench scenarios can show that the correct region is chosen when change lines are out of order, that equal toggles cancel, and that a toggle at 0xFFF shows up only at the wrap to pixel 4095. The bench compares `pulse_o` against a model at every pixel, over random patterns and random line lengths.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } src_e;
endpackage

// File: rtl/lrs_counters.sv
module lrs_counters #(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hsync_i,
  input  logic          vsync_i,
  output logic [CW-1:0] pix_o,
  output logic [CW-1:0] line_o
);
  logic [CW-1:0] pix_q, line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q  <= '0;
      line_q <= '0;
    end else begin
      pix_q <= hsync_i ? '0 : pix_q + 1'b1;
      if (vsync_i)      line_q <= '0;
      else if (hsync_i) line_q <= line_q + 1'b1;
    end
  end

  assign pix_o  = pix_q;
  assign line_o = line_q;
endmodule

// File: rtl/lrs_region_sel.sv
module lrs_region_sel #(
  parameter int CW   = 12,
  parameter int NCHG = 4,
  parameter int PW   = 2
) (
  input  logic [CW-1:0]          line_i,
  input  logic [(NCHG-1)*CW-1:0] chg_line_i,
  input  logic [NCHG*PW-1:0]     chg_ptr_i,
  output logic [PW-1:0]          sel_o
);
  localparam int IW = (NCHG > 1) ? $clog2(NCHG) : 1;

  logic [IW-1:0] idx;

  // ascending scan: a later hit overrides, so the highest index wins
  always_comb begin
    idx = '0;
    for (int k = 1; k < NCHG; k++) begin
      if (chg_line_i[(k-1)*CW +: CW] <= line_i) idx = IW'(k);
    end
    sel_o = chg_ptr_i[idx*PW +: PW];
  end
endmodule

// File: rtl/lrs_seq_eval.sv
module lrs_seq_eval #(
  parameter int CW = 12
) (
  input  logic [CW-1:0] pix_i,
  input  logic          pol_i,
  input  logic [CW-1:0] tog_a_i,
  input  logic [CW-1:0] tog_b_i,
  output logic          level_o
);
  logic past_a, past_b;

  assign past_a  = (pix_i >= tog_a_i);
  assign past_b  = (pix_i >= tog_b_i);
  // equal toggles flip twice and cancel
  assign level_o = pol_i ^ past_a ^ past_b;
endmodule

// File: rtl/lrs_pulse_seq.sv
module lrs_pulse_seq
  import lrs_pkg::*;
#(
  parameter int CW   = 12,
  parameter int NSEQ = 4,
  parameter int NCHG = 4,
  localparam int PW  = $clog2(NSEQ)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   hsync_i,
  input  logic                   vsync_i,
  input  logic [NSEQ-1:0]        seq_pol_i,
  input  logic [NSEQ*CW-1:0]     seq_tog_a_i,
  input  logic [NSEQ*CW-1:0]     seq_tog_b_i,
  input  logic [(NCHG-1)*CW-1:0] chg_line_i,
  input  logic [NCHG*PW-1:0]     chg_ptr_i,
  input  logic                   ext_mode_i,
  input  logic                   ext_pol_i,
  input  logic                   ext_pulse_i,
  output logic                   pulse_o
);
  logic [CW-1:0]   pix_cnt, line_cnt;
  logic [PW-1:0]   seq_sel;
  logic [NSEQ-1:0] seq_level;
  logic            int_pulse, ext_norm;
  src_e            src;

  lrs_counters #(.CW(CW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hsync_i(hsync_i),
    .vsync_i(vsync_i),
    .pix_o  (pix_cnt),
    .line_o (line_cnt)
  );

  lrs_region_sel #(.CW(CW), .NCHG(NCHG), .PW(PW)) u_sel (
    .line_i    (line_cnt),
    .chg_line_i(chg_line_i),
    .chg_ptr_i (chg_ptr_i),
    .sel_o     (seq_sel)
  );

  for (genvar s = 0; s < NSEQ; s++) begin : g_seq
    lrs_seq_eval #(.CW(CW)) u_eval (
      .pix_i  (pix_cnt),
      .pol_i  (seq_pol_i[s]),
      .tog_a_i(seq_tog_a_i[s*CW +: CW]),
      .tog_b_i(seq_tog_b_i[s*CW +: CW]),
      .level_o(seq_level[s])
    );
  end

  assign int_pulse = seq_level[seq_sel];
  assign ext_norm  = ext_pol_i ? ext_pulse_i : ~ext_pulse_i;
  assign src       = src_e'(ext_mode_i);
  assign pulse_o   = (src == SRC_EXT) ? ext_norm : int_pulse;
endmodule

// File: rtl/lrs_pulse_seq_chk.sv
module lrs_pulse_seq_chk #(
  parameter int CW   = 12,
  parameter int NSEQ = 4,
  parameter int NCHG = 4,
  parameter int PW   = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   hsync_i,
  input logic                   vsync_i,
  input logic [CW-1:0]          pix_i,
  input logic [CW-1:0]          line_i,
  input logic [NSEQ-1:0]        seq_pol_i,
  input logic [NSEQ*CW-1:0]     seq_tog_a_i,
  input logic [NSEQ*CW-1:0]     seq_tog_b_i,
  input logic [(NCHG-1)*CW-1:0] chg_line_i,
  input logic [NCHG*PW-1:0]     chg_ptr_i,
  input logic                   ext_mode_i,
  input logic                   ext_pol_i,
  input logic                   ext_pulse_i,
  input logic                   pulse_o
);
  logic          below_all;
  logic [PW-1:0] base_sel;
  logic          base_tog_nz;

  always_comb begin
    below_all = 1'b1;
    for (int k = 1; k < NCHG; k++) begin
      if (chg_line_i[(k-1)*CW +: CW] <= line_i) below_all = 1'b0;
    end
  end

  assign base_sel    = chg_ptr_i[PW-1:0];
  assign base_tog_nz = (seq_tog_a_i[base_sel*CW +: CW] != '0) &&
                       (seq_tog_b_i[base_sel*CW +: CW] != '0);

  a_r1_pix_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_i |=> pix_i == '0);

  a_r1_pix_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsync_i |=> pix_i == CW'($past(pix_i) + 1'b1));

  a_r2_line_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_i |=> line_i == '0);

  a_r2_line_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hsync_i && !vsync_i) |=> line_i == CW'($past(line_i) + 1'b1));

  a_r2_line_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hsync_i && !vsync_i) |=> $stable(line_i));

  a_r5_base_region: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_mode_i && below_all && pix_i == '0 && base_tog_nz)
      |-> pulse_o == seq_pol_i[base_sel]);

  a_r7_ext_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_mode_i && $past(ext_mode_i) && $stable(ext_pulse_i) && $stable(ext_pol_i))
      |-> $stable(pulse_o));
endmodule

bind lrs_pulse_seq lrs_pulse_seq_chk #(
  .CW(CW), .NSEQ(NSEQ), .NCHG(NCHG), .PW(PW)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hsync_i    (hsync_i),
  .vsync_i    (vsync_i),
  .pix_i      (pix_cnt),
  .line_i     (line_cnt),
  .seq_pol_i  (seq_pol_i),
  .seq_tog_a_i(seq_tog_a_i),
  .seq_tog_b_i(seq_tog_b_i),
  .chg_line_i (chg_line_i),
  .chg_ptr_i  (chg_ptr_i),
  .ext_mode_i (ext_mode_i),
  .ext_pol_i  (ext_pol_i),
  .ext_pulse_i(ext_pulse_i),
  .pulse_o    (pulse_o)
);

// File: tb/lrs_pulse_seq_test.sv
`timescale 1ns/1ps
module lrs_pulse_seq_test;
  localparam int CW = 12, NSEQ = 4, NCHG = 4, PW = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic hsync_i = 1'b0, vsync_i = 1'b0;
  logic ext_mode_i = 1'b0, ext_pol_i = 1'b0, ext_pulse_i = 1'b0;
  logic [NSEQ-1:0]        seq_pol_i;
  logic [NSEQ*CW-1:0]     seq_tog_a_i, seq_tog_b_i;
  logic [(NCHG-1)*CW-1:0] chg_line_i;
  logic [NCHG*PW-1:0]     chg_ptr_i;
  logic pulse_o;

  logic          b_pol[NSEQ];
  logic [CW-1:0] b_ta[NSEQ], b_tb[NSEQ], b_chg[NCHG];
  logic [PW-1:0] b_ptr[NCHG];
  logic [CW-1:0] mpix = '0, mline = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  always_comb begin
    for (int s = 0; s < NSEQ; s++) begin
      seq_pol_i[s]            = b_pol[s];
      seq_tog_a_i[s*CW +: CW] = b_ta[s];
      seq_tog_b_i[s*CW +: CW] = b_tb[s];
    end
    for (int k = 0; k < NCHG; k++) chg_ptr_i[k*PW +: PW] = b_ptr[k];
    for (int k = 1; k < NCHG; k++) chg_line_i[(k-1)*CW +: CW] = b_chg[k];
  end

  lrs_pulse_seq uut (.*);

  function automatic logic exp_pulse();
    int r = 0;
    logic v;
    logic [PW-1:0] sel;
    if (ext_mode_i) return ext_pol_i ? ext_pulse_i : ~ext_pulse_i;
    for (int k = NCHG-1; k >= 1; k--) begin
      if (b_chg[k] <= mline) begin r = k; break; end
    end
    sel = b_ptr[r];
    v = b_pol[sel];
    if (mpix >= b_ta[sel]) v = ~v;
    if (mpix >= b_tb[sel]) v = ~v;
    return v;
  endfunction

  task automatic chk(input string tag);
    logic e;
    #1;
    e = exp_pulse();
    n_chk++;
    if (pulse_o !== e) begin
      n_bad++;
      $display("FAIL %s: pix=%0d line=%0d pulse_o=%b expected %b", tag, mpix, mline, pulse_o, e);
    end
  endtask

  task automatic cycle(input logic h, input logic v);
    hsync_i = h;
    vsync_i = v;
    @(posedge clk_i);
    if (h) mpix = '0; else mpix = mpix + 1'b1;
    if (v) mline = '0; else if (h) mline = mline + 1'b1;
    @(negedge clk_i);
    hsync_i = 1'b0;
    vsync_i = 1'b0;
  endtask

  task automatic clear_cfg();
    for (int s = 0; s < NSEQ; s++) begin
      b_pol[s] = 1'b0; b_ta[s] = '1; b_tb[s] = '1;
    end
    for (int k = 0; k < NCHG; k++) begin
      b_chg[k] = '1; b_ptr[k] = '0;
    end
  endtask

  task automatic rand_cfg();
    for (int s = 0; s < NSEQ; s++) begin
      b_pol[s] = 1'($urandom);
      b_ta[s]  = ($urandom % 8 == 0) ? 12'hFFF : 12'($urandom % 48);
      b_tb[s]  = ($urandom % 5 == 0) ? b_ta[s] : 12'($urandom % 48);
    end
    for (int k = 0; k < NCHG; k++) begin
      b_ptr[k] = 2'($urandom);
      b_chg[k] = ($urandom % 4 == 0) ? 12'hFFF : 12'($urandom % 12);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    clear_cfg();
    b_ptr[0] = 2'd2; b_pol[2] = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R8 reset state");
    rst_ni = 1'b1;

    // R2: line count steers the region; vsync wins over hsync
    b_chg[1] = 12'd1; b_ptr[1] = 2'd1; b_pol[1] = 1'b0;
    cycle(1'b1, 1'b1); chk("R2 vsync with hsync gives line 0");
    cycle(1'b1, 1'b0); chk("R2 hsync alone increments line");
    cycle(1'b0, 1'b0); chk("R2 line held without strobe");
    cycle(1'b0, 1'b1); chk("R2 vsync alone clears line");

    // R3: equal toggles keep the start level
    clear_cfg();
    b_pol[0] = 1'b1; b_ta[0] = 12'd5; b_tb[0] = 12'd5;
    cycle(1'b1, 1'b1);
    for (int i = 0; i < 12; i++) begin cycle(1'b0, 1'b0); chk("R3 equal toggles"); end
    b_tb[0] = 12'd9;
    cycle(1'b1, 1'b0);
    for (int i = 0; i < 12; i++) begin cycle(1'b0, 1'b0); chk("R3 two toggles"); end

    // R4 and R1 wrap: toggle at 0xFFF quiet until pixel 4095, then wrap to 0
    clear_cfg();
    b_pol[0] = 1'b0; b_ta[0] = 12'hFFF;
    cycle(1'b1, 1'b1);
    for (int i = 0; i < 4100; i++) begin
      cycle(1'b0, 1'b0);
      if (mpix < 12'd4095 && i < 4094) chk("R4 0xFFF toggle unreached");
      else chk("R1 pixel wrap at 4095");
    end

    // R6 directed: out-of-order change lines
    clear_cfg();
    b_chg[1] = 12'd4; b_chg[2] = 12'd2; b_chg[3] = 12'hFFF;
    b_ptr[0] = 2'd0; b_ptr[1] = 2'd1; b_ptr[2] = 2'd2;
    b_pol[0] = 1'b0; b_pol[1] = 1'b1; b_pol[2] = 1'b0; b_pol[3] = 1'b1;
    cycle(1'b1, 1'b1);
    for (int l = 0; l < 7; l++) begin
      cycle(1'b0, 1'b0); chk("R6 unordered change lines");
      cycle(1'b1, 1'b0);
    end

    // R3 R5 R6 random patterns and regions
    for (int f = 0; f < 40; f++) begin
      rand_cfg();
      cycle(1'b1, 1'b1);
      for (int l = 0; l < 12; l++) begin
        int len = 30 + int'($urandom % 30);
        for (int p = 0; p < len; p++) begin
          cycle(1'b0, 1'b0); chk("R3 R5 R6 random field");
        end
        cycle(1'b1, 1'b0); chk("R5 line start");
      end
    end

    // R7 external pass-through while counters keep running
    ext_mode_i = 1'b1;
    for (int i = 0; i < 300; i++) begin
      cycle(1'($urandom % 7 == 0), 1'($urandom % 50 == 0));
      if (i % 50 == 0) ext_pol_i = ~ext_pol_i;
      ext_pulse_i = 1'($urandom);
      if (i % 3 == 0) rand_cfg();
      chk("R7 external mode");
    end
    ext_mode_i = 1'b0;
    cycle(1'b0, 1'b0); chk("R7 back to internal");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule